// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block runs a single bus cycle on a NAND flash device. A cycle is one of four kinds: a command byte write, an address byte write, a data byte write, or a data byte read. The host raises a request with the kind, a bank number and the write data. The sequencer then drives the latch-enable lines, the write and read strobes, one chip enable out of four and the output enable of the data bus. It returns a one-clock acknowledge, and on a read it also returns the captured byte.

Each phase of the cycle is counted in system clock cycles. The phase lengths come from a 48-bit timing word, one byte per parameter, and the word is sampled once, when a cycle starts. The byte positions are: byte 0 (bits 7:0) sets the command-to-read delay, using its low nibble only. Byte 1 (bits 15:8) sets the address-to-read delay, also using its low nibble only. Byte 2 (bits 23:16) sets the data-bus Hi-Z span. Byte 3 (bits 31:24) sets the hold length. Byte 4 (bits 39:32) sets the strobe length. Byte 5 (bits 47:40) sets the setup length. The setup, strobe and hold bytes, and both delay nibbles, take a value N to mean N+1 cycles. The Hi-Z byte is direct: N means N cycles. An active-low wait input from the device can stretch the strobe.

The cycle kind is encoded on two bits: 0 is command, 1 is address, 2 is data write and 3 is data read. A cycle passes through the phases setup, strobe, an optional wait phase, and hold, and then returns to idle. The data bus is one byte wide.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset and whenever no cycle is running, all four chip enables, the write strobe and the read strobe are high, both latch enables are low, the output enable is low and the acknowledge is low.
- R2: During a cycle, only the chip enable whose index equals the bank number sampled at the start is low. The other three stay high.
- R3: A cycle starts with a setup phase. In this phase the chip enable is low and both strobes are high. The command latch enable is high for kind 0 only, and the address latch enable is high for kind 1 only. For kinds 0, 1 and 2 the setup phase lasts setup byte + 1 cycles.
- R4: The strobe is the write strobe for kinds 0 to 2 and the read strobe for kind 3. It is low for strobe byte + 1 cycles. If the wait input is low in the last of those cycles, the strobe stays low until a cycle in which the wait input is sampled high, and that cycle is the last one with the strobe low.
- R5: The hold phase lasts hold byte + 1 cycles. Through all of it the chip enable, the latch enables and the write data are unchanged and both strobes are high. The acknowledge is high in the last hold cycle only, and the block is idle in the following cycle.
- R6: For a read, the setup phase lasts setup byte + 1 cycles plus an extra delay that depends on the kind of the previous cycle. After a command cycle the extra delay is (byte 0 bits 3:0) + 1. After an address cycle it is (byte 1 bits 3:0) + 1. Otherwise it is zero, and it is also zero when the read is the first cycle after reset. The upper nibbles of bytes 0 and 1 have no effect.
- R7: For kinds 0 to 2, the output enable is low for the first Hi-Z byte cycles of the cycle and high for the remaining cycles. While it is high, the data output carries the write data. For kind 3, the output enable stays low for the whole cycle.
- R8: On a read, the data input is captured at the clock edge that ends the last cycle with the read strobe low. The captured value is on the read-data output when the acknowledge is high, and it stays there until the next read capture.
- R9: The timing word is sampled only when a cycle starts. A change to it during a cycle has no effect on that cycle.
- R10: A request is accepted only while idle. A request raised during a cycle has no effect on that cycle, and its kind and bank are not picked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_cfg | input | 48 | Timing word, one byte per parameter |
| req | input | 1 | Start request, sampled while idle |
| req_kind | input | 2 | Cycle kind: 0 command, 1 address, 2 data write, 3 data read |
| req_bank | input | 2 | Bank number 0 to 3 |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 4 | Chip enables, active low, one per bank |
| nand_dout | output | 8 | Data bus output value |
| nand_doe | output | 1 | Data bus output enable |
| nand_din | input | 8 | Data bus input value |
| nand_wait_n | input | 1 | Device wait, active low |

## Verification
Two events can share one clock edge. The first is the end of the strobe count, which either moves the cycle into hold or, when the wait input is low, into the wait phase. The second is the read capture. The bench provokes this by holding the wait input low across the last strobe cycle for several cycles, and by driving the real read byte only during the last strobe-low cycle while showing its inverse elsewhere. A correct result is an exact strobe-low length of strobe byte + 1 plus the extra wait cycles, with the byte from that single cycle returned with the acknowledge. The same style of collision is also exercised in other ways: a timing word rewritten right after the start edge, and a request raised mid-cycle with a different bank. Both must leave the per-cycle expected outputs unchanged.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int TBW = 8;  // width of one timing byte
  localparam int NBW = 4;  // width of the short delay fields

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WR   = 2'd2,
    K_RD   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_WAIT   = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  typedef struct packed {
    logic [TBW-1:0] setup_n;
    logic [TBW-1:0] strobe_n;
    logic [TBW-1:0] hold_n;
    logic [TBW-1:0] hiz_n;
    logic [NBW-1:0] a2r_n;
    logic [NBW-1:0] c2r_n;
  } tim_t;

  // Split the 48-bit timing word into its fields.
  function automatic tim_t tim_split(input logic [6*TBW-1:0] w);
    tim_t t;
    t.c2r_n    = w[0*TBW +: NBW];
    t.a2r_n    = w[1*TBW +: NBW];
    t.hiz_n    = w[2*TBW +: TBW];
    t.hold_n   = w[3*TBW +: TBW];
    t.strobe_n = w[4*TBW +: TBW];
    t.setup_n  = w[5*TBW +: TBW];
    return t;
  endfunction

endpackage

// File: rtl/nand_tim_snap.sv
module nand_tim_snap
  import nand_seq_pkg::*;
#(
  parameter int CFGW = 6 * TBW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CFGW-1:0] cfg,
  output tim_t            tim
);

  tim_t tim_q;
  tim_t tim_d;

  always_comb begin
    tim_d = tim_q;
    if (load) tim_d = tim_split(cfg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tim_q <= '0;
    else        tim_q <= tim_d;
  end

  assign tim = tim_q;

endmodule

// File: rtl/nand_down_ctr.sv
module nand_down_ctr #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = ld_val;
    else if (en && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

endmodule

// File: rtl/nand_bank_dec.sv
module nand_bank_dec #(
  parameter int NBANK = 4,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             en,
  input  logic [BW-1:0]    sel,
  output logic [NBANK-1:0] ce_n
);

  for (genvar i = 0; i < NBANK; i++) begin : g_ce
    assign ce_n[i] = !(en && (sel == BW'(i)));
  end

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int DW     = 8,
  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CFGW  = 6 * TBW,
  localparam int CW    = TBW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFGW-1:0]  tim_cfg,
  input  logic             req,
  input  logic [1:0]       req_kind,
  input  logic [BW-1:0]    req_bank,
  input  logic [DW-1:0]    req_wdata,
  output logic             ack,
  output logic [DW-1:0]    rdata,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [NBANK-1:0] nand_ce_n,
  output logic [DW-1:0]    nand_dout,
  output logic             nand_doe,
  input  logic [DW-1:0]    nand_din,
  input  logic             nand_wait_n
);

  phase_e         ph_q, ph_d;
  kind_e          kind_q, kind_d;
  kind_e          prev_q, prev_d;
  logic [BW-1:0]  bank_q, bank_d;
  logic [DW-1:0]  wdat_q, wdat_d;
  logic [DW-1:0]  rdat_q, rdat_d;

  tim_t           tim;
  tim_t           tim_live;
  logic           start;
  logic           busy;
  logic           ph_load;
  logic [CW-1:0]  ph_ld_val;
  logic [CW-1:0]  ph_cnt;
  logic           ph_zero;
  logic [TBW-1:0] hz_cnt;
  logic           hz_zero;
  logic [CW-1:0]  rd_extra;
  logic           leave_strobe;

  assign start    = (ph_q == PH_IDLE) && req;
  assign busy     = (ph_q != PH_IDLE);
  assign tim_live = tim_split(tim_cfg);

  // Extra read setup derived from the kind of the previous cycle.
  always_comb begin
    rd_extra = '0;
    if (kind_e'(req_kind) == K_RD) begin
      if (prev_q == K_CMD)       rd_extra = CW'(tim_live.c2r_n) + 1'b1;
      else if (prev_q == K_ADDR) rd_extra = CW'(tim_live.a2r_n) + 1'b1;
    end
  end

  nand_tim_snap #(.CFGW(CFGW)) i_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .cfg   (tim_cfg),
    .tim   (tim)
  );

  nand_down_ctr #(.CW(CW)) i_ph_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ph_load),
    .ld_val (ph_ld_val),
    .en     (busy),
    .cnt    (ph_cnt),
    .zero   (ph_zero)
  );

  nand_down_ctr #(.CW(TBW)) i_hz_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .ld_val (tim_live.hiz_n),
    .en     (busy),
    .cnt    (hz_cnt),
    .zero   (hz_zero)
  );

  nand_bank_dec #(.NBANK(NBANK)) i_bank (
    .en   (busy),
    .sel  (bank_q),
    .ce_n (nand_ce_n)
  );

  // Phase sequencing and counter reload selection.
  always_comb begin
    ph_d         = ph_q;
    ph_load      = 1'b0;
    ph_ld_val    = '0;
    leave_strobe = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req) begin
          ph_d      = PH_SETUP;
          ph_load   = 1'b1;
          ph_ld_val = CW'(tim_live.setup_n) + rd_extra;
        end
      end
      PH_SETUP: begin
        if (ph_zero) begin
          ph_d      = PH_STROBE;
          ph_load   = 1'b1;
          ph_ld_val = CW'(tim.strobe_n);
        end
      end
      PH_STROBE: begin
        if (ph_zero) begin
          if (!nand_wait_n) begin
            ph_d = PH_WAIT;
          end else begin
            ph_d         = PH_HOLD;
            ph_load      = 1'b1;
            ph_ld_val    = CW'(tim.hold_n);
            leave_strobe = 1'b1;
          end
        end
      end
      PH_WAIT: begin
        if (nand_wait_n) begin
          ph_d         = PH_HOLD;
          ph_load      = 1'b1;
          ph_ld_val    = CW'(tim.hold_n);
          leave_strobe = 1'b1;
        end
      end
      PH_HOLD: begin
        if (ph_zero) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // Request capture and read sampling.
  always_comb begin
    kind_d = kind_q;
    prev_d = prev_q;
    bank_d = bank_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    if (start) begin
      kind_d = kind_e'(req_kind);
      prev_d = kind_e'(req_kind);
      bank_d = req_bank;
      wdat_d = req_wdata;
    end
    if (leave_strobe && kind_q == K_RD) rdat_d = nand_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      kind_q <= K_WR;
      prev_q <= K_WR;
      bank_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
      prev_q <= prev_d;
      bank_q <= bank_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  logic strobe_on;
  assign strobe_on = (ph_q == PH_STROBE) || (ph_q == PH_WAIT);

  assign nand_cle  = busy && (kind_q == K_CMD);
  assign nand_ale  = busy && (kind_q == K_ADDR);
  assign nand_we_n = !(strobe_on && kind_q != K_RD);
  assign nand_re_n = !(strobe_on && kind_q == K_RD);
  assign nand_doe  = busy && (kind_q != K_RD) && hz_zero;
  assign nand_dout = wdat_q;
  assign ack       = (ph_q == PH_HOLD) && ph_zero;
  assign rdata     = rdat_q;

  logic unused_cnt;
  assign unused_cnt = ^{ph_cnt, hz_cnt, tim.hiz_n, tim.setup_n, tim.a2r_n, tim.c2r_n};

endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk #(
  parameter int NBANK = 4,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic [DW-1:0]    rdata,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic             nand_we_n,
  input logic             nand_re_n,
  input logic [NBANK-1:0] nand_ce_n,
  input logic             nand_doe
);

  logic idle;
  assign idle = &nand_ce_n;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_doe && !ack));

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  // R3
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_we_n) || $fell(nand_re_n)) |-> !$past(idle));

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && idle));

  // R7
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_doe);

  // R8
  rdata_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(!nand_re_n));

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.NBANK(NBANK), .DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .rdata     (rdata),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale),
  .nand_we_n (nand_we_n),
  .nand_re_n (nand_re_n),
  .nand_ce_n (nand_ce_n),
  .nand_doe  (nand_doe)
);

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] tim_cfg;
  logic        req;
  logic [1:0]  req_kind;
  logic [1:0]  req_bank;
  logic [7:0]  req_wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic [3:0]  nand_ce_n;
  logic [7:0]  nand_dout;
  logic [7:0]  nand_din;
  logic        nand_wait_n;

  int checks = 0;
  int errors = 0;
  int m_prev = 2;     // kind of the previous cycle in the model
  int m_rdata = 0;    // last captured read byte in the model

  always #10 clk = ~clk;

  nand_cycle_seq i_nand_cycle_seq (
    .clk, .rst_n, .tim_cfg, .req, .req_kind, .req_bank, .req_wdata,
    .ack, .rdata, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n,
    .nand_ce_n, .nand_dout, .nand_doe, .nand_din, .nand_wait_n
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(nand_ce_n == 4'hF, tag, nand_ce_n, 4'hF);
    chk({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_doe, ack} == 6'b110000,
        tag, {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_doe, ack}, 6'b110000);
  endtask

  function automatic logic [47:0] mk(input int c2r, input int a2r, input int hz,
                                     input int hd, input int st, input int su);
    return {su[7:0], st[7:0], hd[7:0], hz[7:0], a2r[7:0], c2r[7:0]};
  endfunction

  // One bus cycle against a behavioural per-clock model.
  task automatic run_cyc(input int kd, input int bk, input int wd, input int rd,
                         input int wx, input logic [47:0] cfg_mid, input bit poke);
    int s, w, h, z, c, a, ex, sl, so, tot;
    bit strobe, wr;
    c  = tim_cfg[3:0];
    a  = tim_cfg[11:8];
    z  = tim_cfg[23:16];
    h  = tim_cfg[31:24];
    w  = tim_cfg[39:32];
    s  = tim_cfg[47:40];
    ex = (kd == 3) ? ((m_prev == 0) ? c + 1 : (m_prev == 1) ? a + 1 : 0) : 0;
    sl = s + 1 + ex;
    so = sl + w + 1 + wx;          // first hold cycle index
    tot = so + h + 1;
    wr = (kd != 3);
    @(negedge clk);
    req = 1'b1; req_kind = kd[1:0]; req_bank = bk[1:0]; req_wdata = wd[7:0];
    nand_wait_n = (wx == 0);
    nand_din = ~rd[7:0];
    for (int k = 0; k < tot; k++) begin
      @(negedge clk);
      strobe = (k >= sl) && (k < so);
      // R2
      chk(nand_ce_n == ~(4'b1 << bk), "R2 chip enable", nand_ce_n, ~(4'b1 << bk) & 4'hF);
      // R3 (latch enables; held through hold per R5)
      chk(nand_cle == (kd == 0) && nand_ale == (kd == 1), "R3 latch enables",
          {nand_cle, nand_ale}, {kd == 0, kd == 1});
      // R4 / R6 strobe placement
      chk(nand_we_n == !(strobe && wr), (kd == 3) ? "R6 write strobe" : "R4 write strobe",
          nand_we_n, !(strobe && wr));
      chk(nand_re_n == !(strobe && !wr), (kd == 3) ? "R6 read strobe" : "R4 read strobe",
          nand_re_n, !(strobe && !wr));
      // R7
      chk(nand_doe == (wr && k >= z), "R7 output enable", nand_doe, wr && k >= z);
      if (nand_doe) chk(nand_dout == wd[7:0], "R7 data out", nand_dout, wd);
      // R5
      chk(ack == (k == tot - 1), "R5 ack", ack, k == tot - 1);
      if (!wr && k == tot - 1) begin
        m_rdata = rd;
        // R8
        chk(rdata == rd[7:0], "R8 read data", rdata, rd);
      end
      if (k == 0) begin
        req = 1'b0;
        tim_cfg = cfg_mid;         // R9: rewrite after start
      end
      if (poke && k == 2) begin    // R10: request while busy
        req = 1'b1; req_bank = bk[1:0] ^ 2'd1; req_kind = (kd == 3) ? 2'd0 : 2'd3;
      end
      if (poke && k == 3) req = 1'b0;
      nand_wait_n = (wx == 0) || (k >= so - 1);
      nand_din = (k == so - 1) ? rd[7:0] : ~rd[7:0];
    end
    m_prev = kd;
    @(negedge clk);
    chk_idle("R10 idle after cycle");
    chk(rdata == m_rdata[7:0], "R8 read data held", rdata, m_rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_kind = 2'd0; req_bank = 2'd0; req_wdata = 8'h00;
    nand_din = 8'h00; nand_wait_n = 1'b1;
    tim_cfg = mk(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_idle("R1 reset");
    chk(rdata == 8'h00, "R1 rdata reset", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 idle after release");

    // Minimal lengths, each kind and bank.
    run_cyc(0, 0, 8'hA5, 0, 0, mk(0, 0, 0, 0, 0, 0), 0);
    run_cyc(1, 1, 8'h3C, 0, 0, mk(0, 0, 0, 0, 0, 0), 0);
    run_cyc(2, 2, 8'h77, 0, 0, mk(0, 0, 0, 0, 0, 0), 0);
    run_cyc(3, 3, 0, 8'h5A, 0, mk(0, 0, 0, 0, 0, 0), 0);

    // Longer phases with Hi-Z, R3 R5 R7.
    tim_cfg = mk(2, 3, 4, 3, 2, 5);
    run_cyc(2, 1, 8'hC3, 0, 0, tim_cfg, 0);
    // Hi-Z longer than the whole cycle: output stays off (R7).
    tim_cfg = mk(0, 0, 40, 1, 1, 1);
    run_cyc(0, 2, 8'h11, 0, 0, tim_cfg, 0);

    // R6: read after command, upper nibble ignored.
    tim_cfg = mk(8'hF3, 8'hE5, 0, 1, 1, 2);
    run_cyc(0, 0, 8'h90, 0, 0, tim_cfg, 0);
    run_cyc(3, 0, 0, 8'hE1, 0, tim_cfg, 0);
    // R6: read after address.
    run_cyc(1, 0, 8'h22, 0, 0, tim_cfg, 0);
    run_cyc(3, 0, 0, 8'h1E, 0, tim_cfg, 0);
    // R6: read after read, no extra delay.
    run_cyc(3, 1, 0, 8'h66, 0, tim_cfg, 0);

    // R4 / R8: wait stretch coinciding with read capture.
    tim_cfg = mk(1, 1, 0, 2, 3, 1);
    run_cyc(3, 2, 0, 8'hB4, 4, tim_cfg, 0);
    run_cyc(2, 3, 8'h4B, 0, 1, tim_cfg, 0);
    run_cyc(0, 1, 8'h0F, 0, 6, tim_cfg, 0);

    // R9: rewrite timing word mid-cycle; R10: request while busy.
    tim_cfg = mk(1, 2, 2, 4, 3, 2);
    run_cyc(2, 0, 8'hD2, 0, 0, mk(9, 9, 0, 0, 9, 9), 1);
    tim_cfg = mk(1, 2, 0, 1, 2, 0);
    run_cyc(1, 3, 8'h81, 0, 2, mk(0, 0, 9, 12, 0, 7), 1);
    run_cyc(3, 2, 0, 8'h39, 1, mk(5, 5, 5, 5, 5, 5), 1);

    // Large counts.
    tim_cfg = mk(15, 15, 200, 255, 255, 255);
    run_cyc(0, 3, 8'hEE, 0, 0, tim_cfg, 0);
    run_cyc(3, 3, 0, 8'hC7, 3, tim_cfg, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule